// File: doc/BRIEF.md
# Thread Yield Qualifier Unit

This unit judges a yield request made by the thread context that is running. The request carries a signed source operand and a qualifier mask. The unit also sees a small set of status bits for the calling context: its binding to a virtual processor and a context slot, whether it is dynamically allocatable, whether it is halted, whether it is active, and whether it is dirty. It also sees the policy bit that lets the scheduler intervene on a yield.

The sign and value of the source operand pick one of four paths:
- **Zero** asks the unit to deactivate the caller.
- **A positive value** asks for a qualifier check, which fails when the mask is empty.
- **The value -2** passes through with no effect.
- **Any other negative value** asks for a policy check.

A failed check raises a thread fault and carries a path-specific exception code. In every case the unit returns the source ANDed with the mask as the result for the destination register. Scheduling, and waking a yielded context on qualifier events, happen elsewhere.

A request is presented for one cycle on `req_valid`. All decisions are made combinationally in that cycle. The response is registered and appears on the outputs one clock later, for exactly one cycle.

Top module: `yield_qual_unit`

## Requirements
- R1: With source 0, the unit pulses `rsp_deactivate` when all four conditions hold: the binding inputs equal the caller's own processor and slot numbers, the caller is dynamically allocatable, it is not halted, and it is active. The dirty and policy bits have no effect on this path.
- R2: With source 0, `rsp_deactivate` stays low and no fault is raised if any one of the four deactivation conditions fails.
- R3: With a positive source (sign bit 0, value not 0) and a mask of all zeros, the unit raises `rsp_fault` with `rsp_exc_code` = 3'd2. The dirty and policy bits have no effect on this path.
- R4: With a positive source and a nonzero mask, no fault and no deactivation occur.
- R5: With a negative source other than -2, the unit raises `rsp_fault` with `rsp_exc_code` = 3'd4 when both `intervene_en` and `ctx_dirty` are 1, whatever the mask holds.
- R6: With a negative source other than -2, no fault occurs if either `intervene_en` or `ctx_dirty` is 0.
- R7: A source of -2 (two's complement) raises no fault and causes no deactivation, whatever the status bits and the mask hold.
- R8: `rsp_result` equals the bitwise AND of the source and the mask of the request it answers.
- R9: A request sampled at a rising edge produces `rsp_valid` = 1 in the cycle after that edge. With no request, `rsp_valid`, `rsp_fault`, `rsp_deactivate`, `rsp_exc_code` and `rsp_result` are all 0.
- R10: `rsp_exc_code` is 0 whenever `rsp_fault` is 0, and `rsp_deactivate` is never high in the same cycle as `rsp_fault`.
- R11: While `rst` is high, and in the cycle after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Yield request strobe, one cycle |
| src_value | input | DATA_W | Signed source operand |
| qual_mask | input | DATA_W | Yield qualifier mask |
| self_vp | input | VP_W | Virtual processor number of the caller |
| self_ctx | input | CTX_W | Context slot number of the caller |
| bind_vp | input | VP_W | Virtual processor the caller is bound to |
| bind_ctx | input | CTX_W | Context slot the caller is bound to |
| ctx_dyn_alloc | input | 1 | Caller is dynamically allocatable |
| ctx_halted | input | 1 | Caller is halted |
| ctx_active | input | 1 | Caller's activated bit |
| ctx_dirty | input | 1 | Caller's dirty flag |
| intervene_en | input | 1 | Scheduler intervention on yield is enabled |
| rsp_valid | output | 1 | Response present |
| rsp_result | output | DATA_W | Source AND mask |
| rsp_fault | output | 1 | Thread fault raised |
| rsp_exc_code | output | 3 | Exception code, 0 when no fault |
| rsp_deactivate | output | 1 | Clear the caller's activated bit |

## Verification
The bench targets the boundaries of the sign decode: zero, -2, -1, -3, the most negative value and the largest positive value. A design that tested only the sign bit, or compared against -1 instead of -2, would fault on the pass-through value or miss a policy fault. Each deactivation condition is knocked out on its own, so a design that dropped one term of the conjunction would clear an active context it should leave alone. The bench also sets the dirty and policy bits on the zero and positive paths, and sets a zero mask on the policy path, which catches decoders that leak one path's condition into another. Back-to-back requests, idle cycles after a fault, and a reset asserted right after a request show whether stale codes or results survive.

// File: rtl/yq_pkg.sv
package yq_pkg;

    typedef enum logic [1:0] {
        SEL_RETIRE = 2'd0,
        SEL_QUAL   = 2'd1,
        SEL_POLICY = 2'd2,
        SEL_PASS   = 2'd3
    } yq_sel_e;

    typedef struct packed {
        logic       fault;
        logic [2:0] code;
        logic       deact;
    } yq_verdict_t;

    localparam logic [2:0] EXC_NONE   = 3'd0;
    localparam logic [2:0] EXC_QUAL   = 3'd2;
    localparam logic [2:0] EXC_POLICY = 3'd4;

    function automatic yq_verdict_t verdict_none();
        yq_verdict_t v;
        v.fault = 1'b0;
        v.code  = EXC_NONE;
        v.deact = 1'b0;
        return v;
    endfunction

    function automatic yq_verdict_t verdict_fault(input logic [2:0] c);
        yq_verdict_t v;
        v.fault = 1'b1;
        v.code  = c;
        v.deact = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/yq_selector.sv
module yq_selector #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    output yq_pkg::yq_sel_e   sel
);
    import yq_pkg::*;

    localparam logic [DATA_W-1:0] PASS_VAL = {{(DATA_W-1){1'b1}}, 1'b0};

    always_comb begin
        if (src == '0) begin
            sel = SEL_RETIRE;
        end else if (!src[DATA_W-1]) begin
            sel = SEL_QUAL;
        end else if (src == PASS_VAL) begin
            sel = SEL_PASS;
        end else begin
            sel = SEL_POLICY;
        end
    end
endmodule

// File: rtl/yq_verdict.sv
module yq_verdict #(
    parameter int DATA_W = 32,
    parameter int VP_W   = 4,
    parameter int CTX_W  = 4
) (
    input  yq_pkg::yq_sel_e     sel,
    input  logic [DATA_W-1:0]   mask,
    input  logic [VP_W-1:0]     self_vp,
    input  logic [CTX_W-1:0]    self_ctx,
    input  logic [VP_W-1:0]     bind_vp,
    input  logic [CTX_W-1:0]    bind_ctx,
    input  logic                dyn_alloc,
    input  logic                halted,
    input  logic                active,
    input  logic                dirty,
    input  logic                ien,
    output yq_pkg::yq_verdict_t verdict
);
    import yq_pkg::*;

    logic bound_self;
    logic may_retire;

    assign bound_self = (bind_vp == self_vp) && (bind_ctx == self_ctx);
    assign may_retire = bound_self && dyn_alloc && !halted && active;

    always_comb begin
        verdict = verdict_none();
        case (sel)
            SEL_RETIRE: verdict.deact = may_retire;
            SEL_QUAL: begin
                if (mask == '0) verdict = verdict_fault(EXC_QUAL);
            end
            SEL_POLICY: begin
                if (ien && dirty) verdict = verdict_fault(EXC_POLICY);
            end
            default: verdict = verdict_none();
        endcase
    end
endmodule

// File: rtl/yq_resp_reg.sv
module yq_resp_reg #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [DATA_W-1:0]   result_d,
    input  yq_pkg::yq_verdict_t verdict_d,
    output logic                valid_q,
    output logic [DATA_W-1:0]   result_q,
    output yq_pkg::yq_verdict_t verdict_q
);
    import yq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || !load) begin
            valid_q   <= 1'b0;
            result_q  <= '0;
            verdict_q <= verdict_none();
        end else begin
            valid_q   <= 1'b1;
            result_q  <= result_d;
            verdict_q <= verdict_d;
        end
    end
endmodule

// File: rtl/yield_qual_unit.sv
module yield_qual_unit #(
    parameter int DATA_W = 32,
    parameter int VP_W   = 4,
    parameter int CTX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] src_value,
    input  logic [DATA_W-1:0] qual_mask,
    input  logic [VP_W-1:0]   self_vp,
    input  logic [CTX_W-1:0]  self_ctx,
    input  logic [VP_W-1:0]   bind_vp,
    input  logic [CTX_W-1:0]  bind_ctx,
    input  logic              ctx_dyn_alloc,
    input  logic              ctx_halted,
    input  logic              ctx_active,
    input  logic              ctx_dirty,
    input  logic              intervene_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_result,
    output logic              rsp_fault,
    output logic [2:0]        rsp_exc_code,
    output logic              rsp_deactivate
);
    import yq_pkg::*;

    yq_sel_e     sel;
    yq_verdict_t verdict_d;
    yq_verdict_t verdict_q;
    logic [DATA_W-1:0] masked;

    assign masked = src_value & qual_mask;

    yq_selector #(.DATA_W(DATA_W)) sel_i (
        .src (src_value),
        .sel (sel)
    );

    yq_verdict #(.DATA_W(DATA_W), .VP_W(VP_W), .CTX_W(CTX_W)) verdict_i (
        .sel       (sel),
        .mask      (qual_mask),
        .self_vp   (self_vp),
        .self_ctx  (self_ctx),
        .bind_vp   (bind_vp),
        .bind_ctx  (bind_ctx),
        .dyn_alloc (ctx_dyn_alloc),
        .halted    (ctx_halted),
        .active    (ctx_active),
        .dirty     (ctx_dirty),
        .ien       (intervene_en),
        .verdict   (verdict_d)
    );

    yq_resp_reg #(.DATA_W(DATA_W)) resp_i (
        .clk       (clk),
        .rst       (rst),
        .load      (req_valid),
        .result_d  (masked),
        .verdict_d (verdict_d),
        .valid_q   (rsp_valid),
        .result_q  (rsp_result),
        .verdict_q (verdict_q)
    );

    assign rsp_fault      = verdict_q.fault;
    assign rsp_exc_code   = verdict_q.code;
    assign rsp_deactivate = verdict_q.deact;
endmodule

// File: rtl/yq_checker.sv
module yq_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [DATA_W-1:0] src_value,
    input logic [DATA_W-1:0] qual_mask,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_result,
    input logic              rsp_fault,
    input logic [2:0]        rsp_exc_code,
    input logic              rsp_deactivate
);
    localparam logic [DATA_W-1:0] PASS_VAL = {{(DATA_W-1){1'b1}}, 1'b0};

    // R9
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_fault && !rsp_deactivate && rsp_exc_code == 3'd0));

    // R10
    code_only_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_fault |-> rsp_exc_code == 3'd0);

    // R10
    fault_excludes_deact_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> !rsp_deactivate);

    // R7
    pass_value_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && src_value == PASS_VAL) |=> (!rsp_fault && !rsp_deactivate));

    // R1
    zero_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && src_value == '0) |=> !rsp_fault);

    // R8
    result_masked_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_result == ($past(src_value) & $past(qual_mask)));

    // R3
    qual_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !src_value[DATA_W-1] && src_value != '0 && qual_mask == '0)
        |=> (rsp_fault && rsp_exc_code == 3'd2));
endmodule

bind yield_qual_unit yq_checker #(.DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .src_value      (src_value),
    .qual_mask      (qual_mask),
    .rsp_valid      (rsp_valid),
    .rsp_result     (rsp_result),
    .rsp_fault      (rsp_fault),
    .rsp_exc_code   (rsp_exc_code),
    .rsp_deactivate (rsp_deactivate)
);

// File: tb/yield_qual_unit_tb.sv
module yield_qual_unit_tb_top;
    localparam int DATA_W = 32;
    localparam int VP_W   = 4;
    localparam int CTX_W  = 4;
    localparam int NV     = 16;
    localparam int VW     = 75;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [DATA_W-1:0] src_value;
    logic [DATA_W-1:0] qual_mask;
    logic [VP_W-1:0]   self_vp;
    logic [CTX_W-1:0]  self_ctx;
    logic [VP_W-1:0]   bind_vp;
    logic [CTX_W-1:0]  bind_ctx;
    logic              ctx_dyn_alloc, ctx_halted, ctx_active, ctx_dirty, intervene_en;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_result;
    logic              rsp_fault;
    logic [2:0]        rsp_exc_code;
    logic              rsp_deactivate;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    yield_qual_unit #(.DATA_W(DATA_W), .VP_W(VP_W), .CTX_W(CTX_W)) dut_i (.*);

    // {src, mask, flags{bind_ok,dyn,halt,act,dirty,ien}, expect{fault,code[2:0],deact}}
    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        {32'h0000_0000, 32'h0000_00FF, 6'b110100, 5'b0_000_1}, // R1 all ok
        {32'h0000_0000, 32'h0000_00FF, 6'b111100, 5'b0_000_0}, // R2 halted
        {32'h0000_0000, 32'h0000_00FF, 6'b110000, 5'b0_000_0}, // R2 inactive
        {32'h0000_0000, 32'h0000_00FF, 6'b100100, 5'b0_000_0}, // R2 not dyn
        {32'h0000_0000, 32'h0000_00FF, 6'b010100, 5'b0_000_0}, // R2 bind mismatch
        {32'h0000_0000, 32'h0000_0000, 6'b110111, 5'b0_000_1}, // R1 policy bits ignored
        {32'h0000_0005, 32'h0000_0000, 6'b110100, 5'b1_010_0}, // R3
        {32'h0000_0007, 32'h0000_00F0, 6'b110111, 5'b0_000_0}, // R4
        {32'h0000_0001, 32'h0000_0000, 6'b000011, 5'b1_010_0}, // R3 policy ignored
        {32'hFFFF_FFFF, 32'h0000_FFFF, 6'b000011, 5'b1_100_0}, // R5 -1
        {32'hFFFF_FFFB, 32'h0000_FFFF, 6'b000010, 5'b0_000_0}, // R6 dirty only
        {32'hFFFF_FFFB, 32'h0000_FFFF, 6'b000001, 5'b0_000_0}, // R6 enable only
        {32'hFFFF_FFFE, 32'hFFFF_FFFF, 6'b110111, 5'b0_000_0}, // R7 -2
        {32'hFFFF_FFFD, 32'h0000_0000, 6'b110111, 5'b1_100_0}, // R5 -3 zero mask
        {32'h8000_0000, 32'h0000_0000, 6'b000011, 5'b1_100_0}, // R5 most negative
        {32'h7FFF_FFFF, 32'h0000_0000, 6'b000011, 5'b1_010_0}  // R3 largest positive
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [VW-1:0] v);
        src_value     = v[74:43];
        qual_mask     = v[42:11];
        self_vp       = 4'd3;
        self_ctx      = 4'd5;
        bind_vp       = v[10] ? 4'd3 : 4'd2;
        bind_ctx      = 4'd5;
        ctx_dyn_alloc = v[9];
        ctx_halted    = v[8];
        ctx_active    = v[7];
        ctx_dirty     = v[6];
        intervene_en  = v[5];
        req_valid     = 1'b1;
    endtask

    task automatic check_resp(input string req, input logic [VW-1:0] v);
        check({req, " valid"},  {63'd0, rsp_valid}, 64'd1);
        check({req, " fault"},  {63'd0, rsp_fault}, {63'd0, v[4]});
        check({req, " code"},   {61'd0, rsp_exc_code}, {61'd0, v[3:1]});
        check({req, " deact"},  {63'd0, rsp_deactivate}, {63'd0, v[0]});
        check("R8 result", {32'd0, rsp_result}, {32'd0, v[74:43] & v[42:11]});
    endtask

    task automatic check_idle(input string req);
        check({req, " idle valid"}, {63'd0, rsp_valid}, 64'd0);
        check({req, " idle fault"}, {63'd0, rsp_fault}, 64'd0);
        check({req, " idle code"},  {61'd0, rsp_exc_code}, 64'd0);
        check({req, " idle deact"}, {63'd0, rsp_deactivate}, 64'd0);
        check({req, " idle result"}, {32'd0, rsp_result}, 64'd0);
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        apply(VEC[6]);
        repeat (3) @(posedge clk);
        #1;
        check_idle("R11 in reset");
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b0;
        @(posedge clk); #1;
        check_idle("R11 after release");

        // table walk with back-to-back strobes
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(posedge clk); #1;
            check_resp($sformatf("vec%0d R1..R7", i), VEC[i]);
        end

        // R9: idle cycle right after a fault clears everything
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check_idle("R9");

        // R10: fault response never deactivates even with retire-ready status
        @(negedge clk);
        apply({32'h0000_0009, 32'h0, 6'b110100, 5'b1_010_0});
        @(posedge clk); #1;
        check_resp("R10 fault no deact", {32'h0000_0009, 32'h0, 6'b110100, 5'b1_010_0});

        // R2: slot mismatch only
        @(negedge clk);
        apply(VEC[0]);
        bind_ctx = 4'd6;
        @(posedge clk); #1;
        check("R2 ctx mismatch deact", {63'd0, rsp_deactivate}, 64'd0);

        // R11: reset right after a request drops the response
        @(negedge clk);
        apply(VEC[9]);
        @(posedge clk); #1;
        check("R5 pre-reset fault", {63'd0, rsp_fault}, 64'd1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check_idle("R11 mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b0;
        @(posedge clk); #1;
        check_idle("R9 post reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule